// File: doc/BRIEF.md
# Synchronous ROM Command Port

This block puts a small read-only array behind a clocked, SDRAM-like command port. A host drives chip select, row strobe, column strobe and mode-select levels together with an address bus on each rising clock edge. The port decodes five commands: mode load, row open, burst read, burst stop and the no-operation family. It latches a row and then a column, and returns a burst of data words after a programmable row-to-column gap and a programmable read latency. A width pin chooses 16-bit or 32-bit beats at column time. A mask input blanks output beats two cycles after it is sampled, and a clock-enable input freezes the whole port.

High impedance is shown as a low `dataOe`, and `dataOut` reads zero while it is low. The array contents are computed, not stored. Each 16-bit entry is a fixed hash of its row/column index, and a 32-bit beat carries the inverted hash in its upper half.

Top module: `srom_cmd_port`

## Requirements
- R1: An edge is active when `clkEn` is high at that edge or was high at the previous edge (before the first edge, the previous value counts as high). On any other edge no state and no output changes.
- R2: With `chipSelN` high, nothing is decoded. With it low, the {rowStrbN,colStrbN,modeSelN} codes 111, 010, 001 and 100 are no-operations and leave the burst and the open row untouched.
- R3: Code 000 loads addr[6:0] into the mode register. Commands on the next three active edges are ignored and raise no error.
- R4: Mode fields: bits [2:0] give the burst length (0:1, 1:2, 2:4, 3 to 7:8), bit 3 selects interleaved order, bits [5:4] give the read latency (0 counts as 1), and bit 6 selects a row gap of 2 (0 gives 1). After reset the mode is 7'h22, `dataOe` is low and `protoErr` is low.
- R5: Code 011 latches addr[7:0] as the row. Code 101 latches addr[7:0] as the column. A beat reads index row*256+column.
- R6: A read is accepted only if a row is open and at least the row gap in active edges has passed since the row open. Otherwise it is dropped, and `protoErr` is high for the following active cycle.
- R7: The first beat of an accepted read is driven after the active edge that lies the read latency after the read edge. Later beats follow on consecutive active edges.
- R8: Beat n takes its column from the burst-aligned block of the start column. Its low bits are (col+n) mod length when sequential, and col xor n when interleaved.
- R9: After the last beat `dataOe` falls. A new read accepted while a burst is running replaces the remaining beats, and with a read every burst length the output stays driven without a gap.
- R10: Code 110 stops the burst. The output falls after the active edge that lies the read latency after the stop edge.
- R11: `outMask` sampled high at active edge k blanks the beat due after active edge k+2. The blanked beat is still consumed.
- R12: `wideSel` is sampled with the read. When it is high a beat is {~h,h}; when it is low a beat is {16'h0,h}.
- R13: Entry h(i) = ((i*40503) xor 16'h5A5A) mod 65536. While `dataOe` is low, `dataOut` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| clkEn | input | 1 | Clock enable, suspends the port |
| chipSelN | input | 1 | Active-low chip select |
| rowStrbN | input | 1 | Row strobe command level |
| colStrbN | input | 1 | Column strobe command level |
| modeSelN | input | 1 | Mode select command level |
| addr | input | ADDR_W | Row, column or mode value |
| outMask | input | 1 | Output mask, two-cycle latency |
| wideSel | input | 1 | 1: 32-bit beats, 0: 16-bit beats |
| dataOut | output | 2*WORD_W | Beat data, zero when not driven |
| dataOe | output | 1 | Output driven (low = high impedance) |
| protoErr | output | 1 | Rejected read pulse |

## Verification
The bench aims at reads that land one edge short of the row gap. A port that counted the gap wrongly would accept such a read or reject a legal one, and `protoErr` and the data would then disagree with the model. It issues a stop both during the data and between a read and its first beat, and it places back-to-back reads exactly one burst apart. A miscounted cut would leak beats or leave a hole in the output. It also drops the clock enable in the middle of a burst, toggles the mask across beats, sends commands during the mode lockout, and sends the no-operation codes that look like SDRAM precharge, refresh and write. Any of these taken as real commands would shift, stretch or corrupt the beats that follow.

// File: rtl/srom_pkg.sv
package srom_pkg;

  typedef enum logic [2:0] {
    CMD_NONE,
    CMD_MODE,
    CMD_ROW,
    CMD_READ,
    CMD_STOP
  } cmd_e;

  // strobes from control to datapath, valid in the cycle before an edge
  typedef struct packed {
    logic       en;
    logic       rowLoad;
    logic       colLoad;
    logic       beatValid;
    logic [2:0] beatNum;
    logic [1:0] burstLog;
    logic       interleave;
    logic [1:0] casLat;
  } strobe_t;

endpackage

// File: rtl/srom_ctrl.sv
module srom_ctrl
  import srom_pkg::*;
#(
  parameter logic [6:0] MODE_DEFAULT = 7'h22
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       clkEn,
  input  logic       chipSelN,
  input  logic       rowStrbN,
  input  logic       colStrbN,
  input  logic       modeSelN,
  input  logic [6:0] modeBits,
  output strobe_t    stb,
  output logic       protoErr
);

  logic       ckePrev;
  logic       en;
  logic [6:0] modeReg;
  logic [1:0] lockCnt;
  logic       rowOpen;
  logic [1:0] sinceRow;
  logic [2:0] remain;
  logic [2:0] nextNum;
  cmd_e       cmd;
  logic [1:0] blCode;
  logic [1:0] casLatEff;
  logic [2:0] lenM1;
  logic       readOk;
  logic       startRead;
  logic       badRead;

  assign en = clkEn | ckePrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ckePrev <= 1'b1;
    else       ckePrev <= clkEn;
  end

  // command decode, blocked while mode lockout runs
  always_comb begin
    cmd = CMD_NONE;
    if (!chipSelN && lockCnt == 2'd0) begin
      case ({rowStrbN, colStrbN, modeSelN})
        3'b000:  cmd = CMD_MODE;
        3'b011:  cmd = CMD_ROW;
        3'b101:  cmd = CMD_READ;
        3'b110:  cmd = CMD_STOP;
        default: cmd = CMD_NONE;
      endcase
    end
  end

  assign blCode    = modeReg[2] ? 2'd3 : modeReg[1:0];
  assign casLatEff = (modeReg[5:4] == 2'd0) ? 2'd1 : modeReg[5:4];
  assign lenM1     = 3'((4'd1 << blCode) - 4'd1);
  assign readOk    = rowOpen && (!modeReg[6] || sinceRow != 2'd0);
  assign startRead = (cmd == CMD_READ) && readOk;
  assign badRead   = (cmd == CMD_READ) && !readOk;

  always_comb begin
    stb            = '0;
    stb.en         = en;
    stb.rowLoad    = en && (cmd == CMD_ROW);
    stb.colLoad    = en && startRead;
    stb.burstLog   = blCode;
    stb.interleave = modeReg[3];
    stb.casLat     = casLatEff;
    if (startRead) begin
      stb.beatValid = 1'b1;
      stb.beatNum   = 3'd0;
    end else if (cmd != CMD_STOP && remain != 3'd0) begin
      stb.beatValid = 1'b1;
      stb.beatNum   = nextNum;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeReg  <= MODE_DEFAULT;
      lockCnt  <= 2'd0;
      rowOpen  <= 1'b0;
      sinceRow <= 2'd0;
      remain   <= 3'd0;
      nextNum  <= 3'd0;
      protoErr <= 1'b0;
    end else if (en) begin
      protoErr <= badRead;
      if (cmd == CMD_MODE) begin
        modeReg <= modeBits;
        lockCnt <= 2'd3;
      end else if (lockCnt != 2'd0) begin
        lockCnt <= lockCnt - 2'd1;
      end
      if (cmd == CMD_ROW) begin
        rowOpen  <= 1'b1;
        sinceRow <= 2'd0;
      end else if (sinceRow != 2'd3) begin
        sinceRow <= sinceRow + 2'd1;
      end
      if (startRead) begin
        remain  <= lenM1;
        nextNum <= 3'd1;
      end else if (cmd == CMD_STOP) begin
        remain <= 3'd0;
      end else if (remain != 3'd0) begin
        remain  <= remain - 3'd1;
        nextNum <= nextNum + 3'd1;
      end
    end
  end

endmodule

// File: rtl/srom_datapath.sv
module srom_datapath
  import srom_pkg::*;
#(
  parameter int ROW_W  = 8,
  parameter int COL_W  = 8,
  parameter int WORD_W = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  strobe_t             stb,
  input  logic [ROW_W-1:0]    rowAddr,
  input  logic [COL_W-1:0]    colAddr,
  input  logic                wideSel,
  input  logic                outMask,
  output logic [2*WORD_W-1:0] dataOut,
  output logic                dataOe
);

  localparam int IDX_W   = ROW_W + COL_W;
  localparam int DEPTH   = 3;

  typedef struct packed {
    logic             valid;
    logic             wide;
    logic [IDX_W-1:0] idx;
  } beat_t;

  logic [ROW_W-1:0] rowReg;
  logic [ROW_W-1:0] burstRow;
  logic [COL_W-1:0] colReg;
  logic             wideReg;
  logic [COL_W-1:0] baseCol;
  logic [ROW_W-1:0] baseRow;
  logic             baseWide;
  logic [COL_W-1:0] lenMask;
  logic [COL_W-1:0] offs;
  logic [COL_W-1:0] beatCol;
  beat_t            newBeat;
  beat_t            pipe [DEPTH];
  beat_t            tap;
  logic             mask1;
  logic             mask2;
  logic [WORD_W-1:0] tapHash;

  function automatic logic [WORD_W-1:0] romHash(input logic [IDX_W-1:0] i);
    logic [31:0] p;
    p = 32'(i) * 32'd40503;
    return WORD_W'(p) ^ WORD_W'(16'h5A5A);
  endfunction

  assign baseCol  = stb.colLoad ? colAddr : colReg;
  assign baseRow  = stb.colLoad ? rowReg  : burstRow;
  assign baseWide = stb.colLoad ? wideSel : wideReg;
  assign lenMask  = COL_W'((32'd1 << stb.burstLog) - 32'd1);
  assign offs     = COL_W'(stb.beatNum);

  always_comb begin
    if (stb.interleave)
      beatCol = (baseCol & ~lenMask) | ((baseCol ^ offs) & lenMask);
    else
      beatCol = (baseCol & ~lenMask) | ((baseCol + offs) & lenMask);
    newBeat.valid = stb.beatValid;
    newBeat.wide  = baseWide;
    newBeat.idx   = {baseRow, beatCol};
  end

  assign tap     = pipe[stb.casLat - 2'd1];
  assign tapHash = romHash(tap.idx);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rowReg   <= '0;
      burstRow <= '0;
      colReg   <= '0;
      wideReg  <= 1'b0;
    end else if (stb.en) begin
      if (stb.rowLoad) rowReg <= rowAddr;
      if (stb.colLoad) begin
        colReg   <= colAddr;
        burstRow <= rowReg;
        wideReg  <= wideSel;
      end
    end
  end

  // latency line: stage j holds the beat issued j+1 active edges ago
  for (genvar j = 0; j < DEPTH; j++) begin : gStage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)       pipe[j] <= '0;
      else if (stb.en) pipe[j] <= (j == 0) ? newBeat : pipe[(j == 0) ? 0 : j-1];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mask1   <= 1'b0;
      mask2   <= 1'b0;
      dataOe  <= 1'b0;
      dataOut <= '0;
    end else if (stb.en) begin
      mask1  <= outMask;
      mask2  <= mask1;
      dataOe <= tap.valid && !mask2;
      if (tap.valid && !mask2)
        dataOut <= tap.wide ? {~tapHash, tapHash} : {{WORD_W{1'b0}}, tapHash};
      else
        dataOut <= '0;
    end
  end

endmodule

// File: rtl/srom_cmd_port.sv
module srom_cmd_port
  import srom_pkg::*;
#(
  parameter int         ADDR_W       = 8,
  parameter int         ROW_W        = 8,
  parameter int         COL_W        = 8,
  parameter int         WORD_W       = 16,
  parameter logic [6:0] MODE_DEFAULT = 7'h22
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                clkEn,
  input  logic                chipSelN,
  input  logic                rowStrbN,
  input  logic                colStrbN,
  input  logic                modeSelN,
  input  logic [ADDR_W-1:0]   addr,
  input  logic                outMask,
  input  logic                wideSel,
  output logic [2*WORD_W-1:0] dataOut,
  output logic                dataOe,
  output logic                protoErr
);

  strobe_t stb;

  srom_ctrl #(.MODE_DEFAULT(MODE_DEFAULT)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .clkEn    (clkEn),
    .chipSelN (chipSelN),
    .rowStrbN (rowStrbN),
    .colStrbN (colStrbN),
    .modeSelN (modeSelN),
    .modeBits (addr[6:0]),
    .stb      (stb),
    .protoErr (protoErr)
  );

  srom_datapath #(.ROW_W(ROW_W), .COL_W(COL_W), .WORD_W(WORD_W)) uData (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .rowAddr (addr[ROW_W-1:0]),
    .colAddr (addr[COL_W-1:0]),
    .wideSel (wideSel),
    .outMask (outMask),
    .dataOut (dataOut),
    .dataOe  (dataOe)
  );

endmodule

// File: rtl/srom_checker.sv
module srom_checker #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              clkEn,
  input logic              chipSelN,
  input logic              rowStrbN,
  input logic              colStrbN,
  input logic              modeSelN,
  input logic [DATA_W-1:0] dataOut,
  input logic              dataOe,
  input logic              protoErr
);

  assert_undriven_zero_R13: assert property (@(posedge clk) disable iff (!rstN)
    !dataOe |-> dataOut == '0);

  assert_suspend_hold_R1: assert property (@(posedge clk) disable iff (!rstN)
    (!clkEn && !$past(clkEn)) |=> ($stable(dataOut) && $stable(dataOe) && $stable(protoErr)));

  assert_err_cause_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(protoErr) |-> $past(!chipSelN && rowStrbN && !colStrbN && modeSelN));

  assert_mode_lock_R3: assert property (@(posedge clk) disable iff (!rstN)
    (clkEn && !chipSelN && !rowStrbN && !colStrbN && !modeSelN)
      |=> !protoErr ##1 !protoErr ##1 !protoErr ##1 !protoErr);

endmodule

bind srom_cmd_port srom_checker #(.DATA_W(2*WORD_W)) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .clkEn    (clkEn),
  .chipSelN (chipSelN),
  .rowStrbN (rowStrbN),
  .colStrbN (colStrbN),
  .modeSelN (modeSelN),
  .dataOut  (dataOut),
  .dataOe   (dataOe),
  .protoErr (protoErr)
);

// File: tb/sim_srom_cmd_port.sv
`timescale 1ns/1ps
module sim_srom_cmd_port;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cke = 1'b1;
  logic        csN = 1'b1, rasN = 1'b1, casN = 1'b1, mrN = 1'b1;
  logic [7:0]  addr = 8'h00;
  logic        dqm = 1'b0;
  logic        word = 1'b0;
  logic [31:0] dataOut;
  logic        dataOe;
  logic        protoErr;

  always #10 clk = ~clk;

  srom_cmd_port u0 (
    .clk(clk), .rstN(rstN), .clkEn(cke), .chipSelN(csN), .rowStrbN(rasN),
    .colStrbN(casN), .modeSelN(mrN), .addr(addr), .outMask(dqm), .wideSel(word),
    .dataOut(dataOut), .dataOe(dataOe), .protoErr(protoErr)
  );

  int    checks = 0;
  int    fails = 0;
  int    cyc = 0;
  bit    done = 0;
  string curReq = "R4";

  // reference model state
  logic [6:0]  mMode;
  int          mLock, mRowEdge, k;
  bit          mRowOpen, mErr, mPrev;
  int          mRow;
  logic [31:0] sched [int];
  bit          dqmAt [int];

  function automatic int mCl();
    return (mMode[5:4] == 0) ? 1 : int'(mMode[5:4]);
  endfunction

  function automatic int mBl();
    return (mMode[2:0] >= 3) ? 8 : (1 << mMode[2:0]);
  endfunction

  function automatic logic [15:0] hashOf(int i);
    longint p;
    p = longint'(i) * 40503;
    return 16'(p) ^ 16'h5A5A;
  endfunction

  task automatic cutFrom(int x);
    int keys[$];
    foreach (sched[key]) if (key >= x) keys.push_back(key);
    foreach (keys[i]) sched.delete(keys[i]);
  endtask

  task automatic modelRead(int col, bit wide);
    int bl, t0, c, idx;
    logic [15:0] h;
    bl = mBl();
    t0 = k + mCl();
    cutFrom(t0);
    for (int n = 0; n < bl; n++) begin
      if (mMode[3]) c = (col & ~(bl-1)) | ((col ^ n) & (bl-1));
      else          c = (col & ~(bl-1)) | ((col + n) & (bl-1));
      idx = mRow * 256 + c;
      h = hashOf(idx);
      sched[t0+n] = wide ? {~h, h} : {16'h0, h};
    end
  endtask

  always @(posedge clk) begin
    bit en;
    if (!rstN) begin
      mMode = 7'h22; mLock = 0; mRowOpen = 0; mRow = 0; mRowEdge = 0;
      k = 0; mErr = 0; mPrev = 1;
      sched.delete(); dqmAt.delete();
    end else begin
      en = cke || mPrev;
      mPrev = cke;
      if (en) begin
        k++;
        dqmAt[k] = dqm;
        mErr = 0;
        if (mLock > 0) mLock--;
        else if (!csN) begin
          case ({rasN, casN, mrN})
            3'b000: begin mMode = addr[6:0]; mLock = 3; end
            3'b011: begin mRowOpen = 1; mRow = int'(addr); mRowEdge = k; end
            3'b101: begin
              if (mRowOpen && (k - mRowEdge) >= (mMode[6] ? 2 : 1)) modelRead(int'(addr), word);
              else mErr = 1;
            end
            3'b110: cutFrom(k + mCl());
            default: ;
          endcase
        end
      end
    end
  end

  task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h (cycle %0d)", curReq, what, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    bit          expOe;
    logic [31:0] expData;
    if (rstN && !done) begin
      expOe = sched.exists(k) && !(dqmAt.exists(k-2) && dqmAt[k-2]);
      expData = expOe ? sched[k] : 32'h0;
      chk("dataOe", {31'h0, dataOe}, {31'h0, expOe});
      chk("dataOut", dataOut, expData);
      chk("protoErr", {31'h0, protoErr}, {31'h0, mErr});
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      csN = 1; rasN = 1; casN = 1; mrN = 1;
      @(negedge clk);
    end
  endtask

  task automatic cmd(logic r, logic c, logic m, logic [7:0] a);
    csN = 0; rasN = r; casN = c; mrN = m; addr = a;
    @(negedge clk);
    csN = 1; rasN = 1; casN = 1; mrN = 1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    curReq = "R4";
    chk("reset dataOe", {31'h0, dataOe}, 32'h0);
    chk("reset protoErr", {31'h0, protoErr}, 32'h0);
    idle(2);
    // read with no open row
    curReq = "R6";
    cmd(1, 0, 1, 8'h10); idle(2);
    // default mode: BL4 seq CL2 RL1
    curReq = "R5/R7/R13";
    cmd(0, 1, 1, 8'h12); cmd(1, 0, 1, 8'h05); idle(8);
    curReq = "R8";
    cmd(1, 0, 1, 8'h07); idle(8);
    // mode 7B: RL2, CL3, interleaved, BL8; lockout swallows three commands
    curReq = "R3";
    cmd(0, 0, 0, 8'h7B); cmd(1, 0, 1, 8'h00); cmd(0, 1, 1, 8'h33); cmd(1, 0, 1, 8'h01); idle(1);
    curReq = "R6";
    cmd(0, 1, 1, 8'h34); cmd(1, 0, 1, 8'h02);
    curReq = "R7/R8";
    cmd(1, 0, 1, 8'h0B); idle(14);
    curReq = "R12";
    word = 1; cmd(1, 0, 1, 8'h20); word = 0; idle(14);
    // BL2 CL1 seq RL1, gapless reads
    curReq = "R9";
    cmd(0, 0, 0, 8'h11); idle(3);
    cmd(1, 0, 1, 8'h40); idle(1); cmd(1, 0, 1, 8'h51); idle(1); cmd(1, 0, 1, 8'h62); idle(5);
    // BL8 CL2 seq RL1, stops
    curReq = "R10";
    cmd(0, 0, 0, 8'h23); idle(3);
    cmd(1, 0, 1, 8'h60); idle(2); cmd(1, 1, 0, 8'h00); idle(6);
    cmd(1, 0, 1, 8'h70); cmd(1, 1, 0, 8'h00); idle(6);
    curReq = "R11";
    cmd(1, 0, 1, 8'h80); dqm = 1; idle(2); dqm = 0; idle(1); dqm = 1; idle(1); dqm = 0; idle(8);
    curReq = "R1";
    cmd(1, 0, 1, 8'h90); idle(1); cke = 0; idle(3); cke = 1; idle(10);
    cke = 0; cmd(1, 0, 1, 8'hA0); idle(2); cke = 1; idle(12);
    curReq = "R2";
    cmd(1, 0, 1, 8'hB0);
    csN = 1; rasN = 0; casN = 1; mrN = 1; addr = 8'hEE; @(negedge clk);
    csN = 1; rasN = 0; casN = 0; mrN = 0; addr = 8'h7B; @(negedge clk);
    cmd(0, 1, 0, 8'hC1); cmd(0, 0, 1, 8'hC2); cmd(1, 0, 0, 8'hC3); idle(8);
    cmd(1, 0, 1, 8'hB1); idle(12);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule